// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital side of a successive-approximation converter. It waits for a start request from the one source that its configuration selects. The four possible sources are a software write, two timer overflow pulses and an external start pin. When a request is accepted it spends one cycle in a sample phase. It then searches the code one bit per clock, most significant bit first, by driving a trial code to a DAC and reading back a comparator decision.

When the last bit is decided, the finished code is stored as two bytes and a sticky completion flag is raised. The interrupt line reports that flag only while completion interrupts are enabled. When the enable input is low the block is shut down: requests are ignored and any conversion in flight is abandoned.

The analog path is not part of the block. The comparator input stands for the multiplexer, the gain stage and the reference. Its meaning is: 1 when the sampled input is greater than or equal to the present trial code.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cfg_src` selects the only start source that is obeyed: 0 = software write, 1 = timer A overflow, 2 = timer B overflow, 3 = external pin. A request from any other source has no effect.
- R2: A software start is `sw_busy_wr` high with `sw_busy_wdata` = 1. A write with `sw_busy_wdata` = 0 starts nothing.
- R3: The external pin passes through two synchronising flops and starts a conversion only on a rising edge. `busy` rises on the third clock edge after the pin goes high. Holding the pin high does not start a second conversion.
- R4: `busy` rises on the edge that accepts a request and stays high for exactly RES_BITS+1 cycles. During the first of these cycles (the sample cycle) `dac_code` is 0. On the next edge `dac_code` becomes 1 followed by RES_BITS-1 zeros (only the MSB set).
- R5: At each decision edge, the bit under trial is kept when `cmp_in` is 1 and cleared when it is 0, and the next lower bit is set as the new trial. For any input level, the final code equals the input level.
- R6: On completion, `res_lo` takes code bits 7..0 and `res_hi` takes code bits RES_BITS-1..8, zero-extended. The result bytes change at no other time.
- R7: `done` is set on the edge where `busy` falls at completion. It stays set until a `sw_done_clr` pulse. If the clear and a completion fall on the same edge, the completion wins.
- R8: `irq` is high exactly when `done` is 1 and `cfg_int_en` is 1.
- R9: A start request that arrives while `busy` is high is dropped. The running conversion keeps its timing and result, and no second conversion follows.
- R10: While `cfg_enable` is 0, start requests are ignored. Lowering `cfg_enable` during a conversion drops `busy` on the next edge, returns `dac_code` to 0, and leaves `done` and the result bytes unchanged.
- R11: `dac_code` is 0 whenever `busy` is low, including after reset. After reset, `busy`, `done`, `irq` and the result bytes are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | 1 = converter powered; 0 = shutdown |
| cfg_src | input | 2 | Start source select (0 software, 1 timer A, 2 timer B, 3 external pin) |
| cfg_int_en | input | 1 | Completion interrupt enable |
| sw_busy_wr | input | 1 | Software write strobe to the busy bit |
| sw_busy_wdata | input | 1 | Value written to the busy bit; 1 requests a start |
| sw_done_clr | input | 1 | Clears the completion flag |
| tmr_a_ovf | input | 1 | Timer A overflow pulse |
| tmr_b_ovf | input | 1 | Timer B overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| cmp_in | input | 1 | Comparator decision: 1 when input >= trial code |
| dac_code | output | RES_BITS | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky completion flag |
| res_lo | output | 8 | Result bits 7..0 |
| res_hi | output | 8 | Result upper bits, zero-extended |
| irq | output | 1 | Completion interrupt |

## Verification
The search is driven by a bench model of the comparator that answers `vin >= dac_code` for every one of the 4096 possible 12-bit input levels. A wrong keep/clear decision, a skipped bit or a wrong byte split therefore shows up as a code mismatch at a specific level. Each start source is pulsed both while selected and while not selected, which separates correct selection from a source that leaks through. Requests are also issued in three awkward situations: in the middle of a conversion, while shut down, and as a held-high pin. A completion is placed on the same edge as a done-clear. Together these tell dropping apart from queueing, and set priority apart from clear priority.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC trigger sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;

    // Start source encoding; the value is the cfg_src field.
    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_TMR_A = 2'd1,
        SRC_TMR_B = 2'd2,
        SRC_EXT   = 2'd3
    } start_src_e;

    // Phases of one conversion.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/adc_start_select.sv
// Chooses one of four start sources and issues a single-cycle start.
// The external pin is synchronised through SYNC_STAGES flops and
// edge-detected. A request is gated off while busy or shut down.
// Assumes: timer inputs are already synchronous single-cycle pulses;
// SYNC_STAGES >= 2.
module adc_start_select
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  start_src_e src,
    input  logic       enable,
    input  logic       busy,
    input  logic       sw_wr,
    input  logic       sw_wdata,
    input  logic       tmr_a,
    input  logic       tmr_b,
    input  logic       ext_pin,
    output logic       start_req
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          ext_prev;
    logic          ext_rise;
    logic          selected;

    // Shift the external pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], ext_pin};
        end
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
        end else begin
            ext_prev <= sync_q[LAST];
        end
    end

    assign ext_rise = sync_q[LAST] & ~ext_prev;

    // Pick the request of the configured source.
    always_comb begin
        case (src)
            SRC_SOFT:  selected = sw_wr & sw_wdata;
            SRC_TMR_A: selected = tmr_a;
            SRC_TMR_B: selected = tmr_b;
            SRC_EXT:   selected = ext_rise;
            default:   selected = 1'b0;
        endcase
    end

    assign start_req = selected & enable & ~busy;

endmodule

// File: rtl/adc_sar_engine.sv
// Successive-approximation search: one sample cycle, then one bit
// per clock from MSB to LSB. The trial bit is kept when cmp_in is 1.
// finish/final_code are valid combinationally on the last decision edge.
// Assumes: cmp_in is stable before each rising edge; enable low aborts.
module adc_sar_engine
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                start,
    input  logic                cmp_in,
    output logic                busy,
    output logic [RES_BITS-1:0] dac_code,
    output logic                finish,
    output logic [RES_BITS-1:0] final_code
);

    localparam int IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam int MSB_IDX = RES_BITS - 1;

    sar_phase_e          phase;
    logic [IDX_W-1:0]    bit_idx;
    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] decided;
    logic [RES_BITS-1:0] next_trial;
    logic                last_bit;

    // Per-bit decision and next-trial logic.
    for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
        assign decided[b] = (bit_idx == IDX_W'(b)) ? cmp_in : trial[b];
        if (b < MSB_IDX) begin : g_low
            assign next_trial[b] = (bit_idx == IDX_W'(b + 1)) ? 1'b1 : decided[b];
        end else begin : g_top
            assign next_trial[b] = decided[b];
        end
    end

    assign last_bit = (bit_idx == '0);

    // Phase sequencing and trial-code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            trial   <= '0;
        end else if (!enable) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            trial   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SAMPLE;
                    end
                end
                PH_SAMPLE: begin
                    phase   <= PH_CONV;
                    bit_idx <= IDX_W'(MSB_IDX);
                    trial   <= {1'b1, {(RES_BITS-1){1'b0}}};
                end
                PH_CONV: begin
                    if (last_bit) begin
                        phase <= PH_IDLE;
                        trial <= '0;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                        trial   <= next_trial;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    trial <= '0;
                end
            endcase
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign dac_code   = trial;
    assign finish     = enable && (phase == PH_CONV) && last_bit;
    assign final_code = decided;

endmodule

// File: rtl/adc_result_bytes.sv
// Holds the finished code as two bytes, low byte and zero-extended high.
// Assumes: RES_BITS between 9 and 16; load is a single-cycle pulse.
module adc_result_bytes #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RES_BITS-1:0] code,
    output logic [7:0]          res_lo,
    output logic [7:0]          res_hi
);

    localparam int WIDE = 16;

    logic [WIDE-1:0] code_wide;

    assign code_wide = WIDE'(code);

    // Capture the code only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (load) begin
            res_lo <= code_wide[7:0];
            res_hi <= code_wide[15:8];
        end
    end

endmodule

// File: rtl/adc_status_flag.sv
// Sticky completion flag with interrupt masking. Set beats clear.
// Assumes: set and clr are synchronous pulses.
module adc_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic int_en,
    output logic done,
    output logic irq
);

    // Hold done until cleared; a set on the same edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (set) begin
            done <= 1'b1;
        end else if (clr) begin
            done <= 1'b0;
        end
    end

    assign irq = done & int_en;

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC trigger sequencer: source select, SAR search,
// result bytes and completion status.
// Assumes: clk is the SAR bit clock; the analog side answers cmp_in
// within one cycle of a dac_code change.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_enable,
    input  logic [1:0]          cfg_src,
    input  logic                cfg_int_en,
    input  logic                sw_busy_wr,
    input  logic                sw_busy_wdata,
    input  logic                sw_done_clr,
    input  logic                tmr_a_ovf,
    input  logic                tmr_b_ovf,
    input  logic                ext_start,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                busy,
    output logic                done,
    output logic [7:0]          res_lo,
    output logic [7:0]          res_hi,
    output logic                irq
);

    logic                start_req;
    logic                finish;
    logic [RES_BITS-1:0] final_code;

    adc_start_select #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (start_src_e'(cfg_src)),
        .enable    (cfg_enable),
        .busy      (busy),
        .sw_wr     (sw_busy_wr),
        .sw_wdata  (sw_busy_wdata),
        .tmr_a     (tmr_a_ovf),
        .tmr_b     (tmr_b_ovf),
        .ext_pin   (ext_start),
        .start_req (start_req)
    );

    adc_sar_engine #(
        .RES_BITS(RES_BITS)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .start      (start_req),
        .cmp_in     (cmp_in),
        .busy       (busy),
        .dac_code   (dac_code),
        .finish     (finish),
        .final_code (final_code)
    );

    adc_result_bytes #(
        .RES_BITS(RES_BITS)
    ) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (finish),
        .code   (final_code),
        .res_lo (res_lo),
        .res_hi (res_hi)
    );

    adc_status_flag u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (finish),
        .clr    (sw_done_clr),
        .int_en (cfg_int_en),
        .done   (done),
        .irq    (irq)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for adc_seq_ctrl, attached by bind below.
// Assumes: the same RES_BITS as the bound instance.
module adc_seq_ctrl_chk #(
    parameter int RES_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_enable,
    input logic                cfg_int_en,
    input logic                sw_done_clr,
    input logic [RES_BITS-1:0] dac_code,
    input logic                busy,
    input logic                done,
    input logic [7:0]          res_lo,
    input logic [7:0]          res_hi,
    input logic                irq
);

    localparam int CNT_W = $clog2(RES_BITS + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;

    // Count consecutive busy cycles to bound a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= CNT_W'(RES_BITS))); // R4
    AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0)); // R11
    AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !busy); // R10
    AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(cfg_enable)) |-> done); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && !$past(sw_done_clr)) |-> done); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_int_en |-> !irq); // R8
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_int_en) |-> irq); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable({res_hi, res_lo})); // R6

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .RES_BITS(RES_BITS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_int_en  (cfg_int_en),
    .sw_done_clr (sw_done_clr),
    .dac_code    (dac_code),
    .busy        (busy),
    .done        (done),
    .res_lo      (res_lo),
    .res_hi      (res_hi),
    .irq         (irq)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Bench for adc_seq_ctrl: exhaustive 12-bit sweep plus source,
// timing and corner-case checks. The comparator is modelled as vin >= dac_code.
module adc_seq_ctrl_tb_top;

    localparam int RB       = 12;
    localparam int WDOG_MAX = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_enable, cfg_int_en, sw_busy_wr, sw_busy_wdata, sw_done_clr;
    logic [1:0]    cfg_src;
    logic          tmr_a_ovf, tmr_b_ovf, ext_start, cmp_in;
    logic [RB-1:0] dac_code;
    logic          busy, done, irq;
    logic [7:0]    res_lo, res_hi;
    int            vin;
    int            checks   = 0;
    int            failures = 0;
    int            cycles   = 0;

    always #4 clk = ~clk;

    assign cmp_in = (vin >= int'(dac_code));

    adc_seq_ctrl #(.RES_BITS(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
        .cfg_int_en(cfg_int_en), .sw_busy_wr(sw_busy_wr), .sw_busy_wdata(sw_busy_wdata),
        .sw_done_clr(sw_done_clr), .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf),
        .ext_start(ext_start), .cmp_in(cmp_in), .dac_code(dac_code), .busy(busy),
        .done(done), .res_lo(res_lo), .res_hi(res_hi), .irq(irq)
    );

    // Watchdog: an over-long run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_MAX) begin
            checks++;
            failures++;
            $display("FAIL R4 watchdog actual=%0d expected<=%0d", cycles, WDOG_MAX);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic sw_write(input logic val);
        sw_busy_wr    = 1'b1;
        sw_busy_wdata = val;
        tick();
        sw_busy_wr    = 1'b0;
        sw_busy_wdata = 1'b0;
    endtask

    task automatic clear_done();
        sw_done_clr = 1'b1;
        tick();
        sw_done_clr = 1'b0;
    endtask

    // Pulse one non-software source for one cycle: 1 timer A, 2 timer B.
    task automatic pulse_tmr(input int which);
        if (which == 1) tmr_a_ovf = 1'b1;
        else            tmr_b_ovf = 1'b1;
        tick();
        tmr_a_ovf = 1'b0;
        tmr_b_ovf = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; cfg_enable = 1'b1; cfg_src = 2'd0; cfg_int_en = 1'b0;
        sw_busy_wr = 1'b0; sw_busy_wdata = 1'b0; sw_done_clr = 1'b0;
        tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0; ext_start = 1'b0; vin = 0;
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        tick();

        // R11: reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 dac", dac_code, 0);
        chk("R11 result", {res_hi, res_lo}, 0);
        chk("R11 irq", irq, 0);

        // R2: writing 0 to busy starts nothing
        sw_write(1'b0);
        tick();
        chk("R2 write0 busy", busy, 0);

        // R4: timing of sample phase and first trial
        vin = 12'h5A3;
        sw_write(1'b1);
        chk("R4 busy rise", busy, 1);
        chk("R4 sample dac", dac_code, 0);
        tick();
        chk("R4 msb trial", dac_code, 12'h800);
        tick();
        chk("R5 second trial", dac_code, 12'h400);
        tick(RB - 2);
        chk("R4 busy last", busy, 1);
        tick();
        chk("R4 busy fall", busy, 0);
        chk("R5 code", {res_hi, res_lo}, 12'h5A3);
        chk("R11 dac idle", dac_code, 0);

        // R7 and R8: sticky done and interrupt mask
        tick(4);
        chk("R7 sticky", done, 1);
        chk("R8 masked", irq, 0);
        cfg_int_en = 1'b1;
        #1;
        chk("R8 raised", irq, 1);
        clear_done();
        chk("R7 cleared", done, 0);
        chk("R8 cleared", irq, 0);
        cfg_int_en = 1'b0;

        // R5, R6, R4: exhaustive sweep of every input level
        for (int v = 0; v < (1 << RB); v++) begin
            vin = v;
            sw_write(1'b1);
            tick(RB);
            chk("R4 sweep busy", busy, 1);
            tick();
            chk("R4 sweep end", busy, 0);
            chk("R6 res_lo", res_lo, v & 8'hFF);
            chk("R6 res_hi", res_hi, v >> 8);
        end
        clear_done();

        // R7: clear and completion on the same edge, set wins
        vin = 12'h0F0;
        sw_write(1'b1);
        tick(RB);
        sw_done_clr = 1'b1;
        tick();
        sw_done_clr = 1'b0;
        chk("R7 set wins", done, 1);
        clear_done();

        // R1: timer A source, others ignored
        cfg_src = 2'd1;
        vin = 12'h123;
        sw_write(1'b1);
        pulse_tmr(2);
        tick();
        chk("R1 srcA ignores sw/B", busy, 0);
        pulse_tmr(1);
        chk("R1 srcA start", busy, 1);
        tick(RB + 1);
        chk("R1 srcA result", {res_hi, res_lo}, 12'h123);

        // R1: timer B source, others ignored
        cfg_src = 2'd2;
        vin = 12'hABC;
        pulse_tmr(1);
        sw_write(1'b1);
        tick();
        chk("R1 srcB ignores sw/A", busy, 0);
        pulse_tmr(2);
        chk("R1 srcB start", busy, 1);
        tick(RB + 1);
        chk("R1 srcB result", {res_hi, res_lo}, 12'hABC);

        // R1: software source ignores timers and pin
        cfg_src = 2'd0;
        pulse_tmr(1);
        pulse_tmr(2);
        ext_start = 1'b1;
        tick(4);
        chk("R1 soft ignores others", busy, 0);
        ext_start = 1'b0;
        tick(3);

        // R3: external pin, two-flop sync, rising edge only
        cfg_src = 2'd3;
        vin = 12'hFFF;
        sw_write(1'b1);
        tick();
        chk("R1 ext ignores sw", busy, 0);
        ext_start = 1'b1;
        tick(2);
        chk("R3 not yet", busy, 0);
        tick();
        chk("R3 third edge", busy, 1);
        tick(RB);
        chk("R3 busy last", busy, 1);
        tick();
        chk("R3 done", busy, 0);
        chk("R3 result", {res_hi, res_lo}, 12'hFFF);
        tick(5);
        chk("R3 held high no restart", busy, 0);
        ext_start = 1'b0;
        tick(3);

        // R9: request while busy is dropped
        cfg_src = 2'd0;
        vin = 12'hA5C;
        sw_write(1'b1);
        tick(5);
        sw_write(1'b1);
        tick(RB - 6);
        chk("R9 still busy", busy, 1);
        tick();
        chk("R9 ends on time", busy, 0);
        chk("R9 result", {res_hi, res_lo}, 12'hA5C);
        tick(3);
        chk("R9 no second run", busy, 0);
        clear_done();

        // R10: abort by shutdown, then starts ignored while off
        vin = 12'h333;
        sw_write(1'b1);
        tick(4);
        cfg_enable = 1'b0;
        tick();
        chk("R10 abort busy", busy, 0);
        chk("R10 abort dac", dac_code, 0);
        chk("R10 abort done", done, 0);
        chk("R10 result kept", {res_hi, res_lo}, 12'hA5C);
        sw_write(1'b1);
        tick(2);
        chk("R10 start ignored", busy, 0);
        cfg_enable = 1'b1;
        tick();
        chk("R10 no late start", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule